// File: doc/BRIEF.md
# Second-Order Fine-Steering Code Dither

This block turns a steering word with sub-LSB resolution into a stream of 16-bit converter codes. The word is unsigned fixed point with 16 integer bits and 8 fractional bits. Each accepted update strobe produces one code. Two cascaded first-order accumulators (a 1-1 cascade) spread the fraction over neighbouring codes, so the running mean of the codes follows the full-precision word. The quantization noise is pushed up in frequency, where the analog filter after the converter removes it.

The word that controls the steering loop is written at any time through a load port and held as a pending value. It becomes active only when an update strobe is accepted. The strobe arrives at the output refresh rate, anywhere from about a hundred to about a hundred thousand per second. Each new code is announced with a one-cycle valid pulse that starts the serial converter writer.

Control is a two-state machine. `ST_HOLD` waits for a strobe. The transition `HOLD->CALC` fires on a strobe: it latches the active word. `ST_CALC` advances the modulator and registers the code. The transition `CALC->HOLD` is unconditional.

Top module: `fine_steer_dither`

## Requirements
- R1: While reset is high on a clock edge, the block clears both accumulators and the carry history. It sets code to the integer part of RESET_WORD (32768 for the default 24'h800000) and drives code_valid low.
- R2: A strobe sampled high in ST_HOLD updates code on the second rising edge after the strobe edge. code_valid is high for exactly that one cycle. code does not change in any other cycle.
- R3: A strobe sampled in ST_CALC, the cycle right after an accepted strobe, is ignored. Two strobe cycles back to back yield exactly one code.
- R4: load_word is stored when load_valid is high but has no effect on code until a strobe is accepted. If load_valid and the accepted strobe fall in the same cycle, the new word is used.
- R5: Bits [23:8] of the word are the integer part I and bits [7:0] are the fraction F. Each step first sets a1 = (a1+F) mod 256 with carry c1. It then sets a2 = (a2+new a1) mod 256 with carry c2. The code is I + c1 + c2 - c2 of the previous step.
- R6: From reset, a word with F = 0 gives code equal to I on every update.
- R7: From reset, a word with F = 0x80 (for example 1000.5) gives only the codes I and I+1. Any 4 consecutive codes sum to 4I+2.
- R8: With a constant word, the sum of any 256 consecutive codes is within 1 of 256*I+F. The mean is therefore within one fractional LSB.
- R9: The code is saturated to the range 0..65535. When I = 65535, the code is 65535 and both accumulators and the carry history are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Store load_word as the pending steering word |
| load_word | input | 24 | Steering word, 16 integer bits and 8 fractional bits |
| upd_stb | input | 1 | Update-rate strobe requesting one new code |
| code_valid | output | 1 | One-cycle pulse marking a new code |
| code | output | 16 | Converter code |

## Verification
Each result is due two rising edges after the strobe edge that is accepted. On that edge, code and code_valid change together, and code_valid falls again one edge later.

The bench drives every input on the falling edge. The monitor samples on the falling edge that follows the code update. The driver queues one expected code per accepted strobe, and the monitor compares it only when it sees the valid pulse. One timing test checks valid low, high, low on three successive falling edges. The ignored-strobe and pending-load tests then confirm that the pulse count and the code are unchanged.

// File: rtl/fine_steer_pkg.sv
package fine_steer_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_CALC = 1'b1
    } dither_state_t;
endpackage

// File: rtl/steer_word_latch.sv
module steer_word_latch #(
    parameter int WORD_W = 24,
    parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid,
    input  logic [WORD_W-1:0] load_word,
    input  logic              take,
    output logic [WORD_W-1:0] active_word
);
    logic [WORD_W-1:0] pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q   <= RESET_WORD;
            active_word <= RESET_WORD;
        end else begin
            if (load_valid) pending_q <= load_word;
            if (take) active_word <= load_valid ? load_word : pending_q;
        end
    end

    // R4: the active word changes only on an accepted strobe
    AST_ACTIVE_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(active_word)); // R4
endmodule

// File: rtl/cascade_accum_core.sv
module cascade_accum_core #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    output logic signed [2:0] delta
);
    logic [FRAC_W-1:0] acc1_q, acc2_q;
    logic              c2_prev_q;
    logic [FRAC_W:0]   sum1, sum2;
    logic              c1, c2;

    always_comb begin
        sum1  = {1'b0, acc1_q} + {1'b0, frac};
        c1    = sum1[FRAC_W];
        sum2  = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
        c2    = sum2[FRAC_W];
        delta = $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, c2_prev_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc1_q    <= '0;
            acc2_q    <= '0;
            c2_prev_q <= 1'b0;
        end else if (advance) begin
            acc1_q    <= sum1[FRAC_W-1:0];
            acc2_q    <= sum2[FRAC_W-1:0];
            c2_prev_q <= c2;
        end
    end

    // R9: accumulators held whenever no step is taken
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(acc1_q) && $stable(acc2_q) && $stable(c2_prev_q))); // R9
    // R6: a zero fraction from cleared state leaves the first accumulator at zero
    AST_ZERO_FRAC_REST: assert property (@(posedge clk) disable iff (rst)
        (advance && frac == '0 && acc1_q == '0) |=> acc1_q == '0); // R6
endmodule

// File: rtl/code_saturate.sv
module code_saturate #(
    parameter int INT_W = 16
) (
    input  logic [INT_W-1:0]  base,
    input  logic signed [2:0] delta,
    output logic [INT_W-1:0]  code_sat
);
    localparam logic signed [INT_W+1:0] TOP = $signed({2'b00, {INT_W{1'b1}}});
    logic signed [INT_W+1:0] wide;

    always_comb begin
        wide = $signed({2'b00, base}) + {{(INT_W-1){delta[2]}}, delta};
        if (wide < 0)        code_sat = '0;
        else if (wide > TOP) code_sat = '1;
        else                 code_sat = wide[INT_W-1:0];
    end
endmodule

// File: rtl/fine_steer_dither.sv
module fine_steer_dither #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    parameter logic [INT_W+FRAC_W-1:0] RESET_WORD = 24'h800000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_valid,
    input  logic [INT_W+FRAC_W-1:0] load_word,
    input  logic                    upd_stb,
    output logic                    code_valid,
    output logic [INT_W-1:0]        code
);
    import fine_steer_pkg::*;

    localparam int WORD_W = INT_W + FRAC_W;
    localparam logic [INT_W-1:0] CODE_MAX = '1;

    dither_state_t     state_q, state_d;
    logic [WORD_W-1:0] active_word;
    logic [INT_W-1:0]  act_int, sat_code;
    logic [FRAC_W-1:0] act_frac;
    logic signed [2:0] delta;
    logic              take, at_top, advance;

    assign take     = (state_q == ST_HOLD) && upd_stb;
    assign act_int  = active_word[WORD_W-1:FRAC_W];
    assign act_frac = active_word[FRAC_W-1:0];
    assign at_top   = (act_int == CODE_MAX);
    assign advance  = (state_q == ST_CALC) && !at_top;

    steer_word_latch #(.WORD_W(WORD_W), .RESET_WORD(RESET_WORD)) u_latch (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_word(load_word),
        .take(take), .active_word(active_word));

    cascade_accum_core #(.FRAC_W(FRAC_W)) u_core (
        .clk(clk), .rst(rst), .advance(advance), .frac(act_frac), .delta(delta));

    code_saturate #(.INT_W(INT_W)) u_sat (
        .base(act_int), .delta(delta), .code_sat(sat_code));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (upd_stb) state_d = ST_CALC;
            ST_CALC: state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_valid <= 1'b0;
            code       <= RESET_WORD[WORD_W-1:FRAC_W];
        end else begin
            code_valid <= (state_q == ST_CALC);
            if (state_q == ST_CALC) code <= at_top ? CODE_MAX : sat_code;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid); // R2
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!code_valid && !$past(rst)) |-> $stable(code)); // R2
    AST_CALC_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALC) |=> (state_q == ST_HOLD && code_valid)); // R3
    AST_TOP_PINNED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALC && at_top) |=> code == CODE_MAX); // R9
    AST_NEAR_INTEGER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CALC && !at_top && act_int != '0)
        |=> (code + 1'b1 >= $past(act_int) && code <= $past(act_int) + 2'd2)); // R5
endmodule

// File: tb/test_fine_steer_dither.sv
module test_fine_steer_dither;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_valid = 1'b0;
    logic [23:0] load_word = '0;
    logic        upd_stb = 1'b0;
    logic        code_valid;
    logic [15:0] code;

    int n_cmp = 0, n_bad = 0, n_valid = 0;
    int exp_q[$];
    int got[$];
    int m_a1, m_a2, m_c2p, m_word, m_pend;

    always #2.5 clk = ~clk;

    fine_steer_dither i_fine_steer_dither (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_word(load_word),
        .upd_stb(upd_stb), .code_valid(code_valid), .code(code));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compare every produced code against the scoreboard
    always @(negedge clk) begin
        if (!rst && code_valid) begin
            n_valid++;
            got.push_back(int'(code));
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected code", int'(code), -1);
            else begin
                int e;
                e = exp_q.pop_front();
                check(int'(code) == e, "R5 scoreboard code", int'(code), e);
            end
        end
    end

    function automatic int model_step();
        int i, f, a1n, a2n, c1, c2, v;
        i = m_word >> 8;
        f = m_word & 255;
        if (i == 65535) return 65535;
        a1n = m_a1 + f; c1 = a1n >> 8; a1n &= 255;
        a2n = m_a2 + a1n; c2 = a2n >> 8; a2n &= 255;
        v = i + c1 + c2 - m_c2p;
        m_a1 = a1n; m_a2 = a2n; m_c2p = c2;
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_a1 = 0; m_a2 = 0; m_c2p = 0; m_word = 24'h800000; m_pend = 24'h800000;
    endtask

    task automatic load(input int w);
        @(negedge clk); load_valid = 1'b1; load_word = w[23:0];
        @(negedge clk); load_valid = 1'b0;
        m_pend = w;
    endtask

    task automatic step();
        @(negedge clk); upd_stb = 1'b1;
        m_word = m_pend;
        exp_q.push_back(model_step());
        @(negedge clk); upd_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base, s, v0;
        // R1 reset state
        do_reset();
        check(code == 16'd32768, "R1 reset code", int'(code), 32768);
        check(code_valid == 1'b0, "R1 reset valid", int'(code_valid), 0);

        // R2 latency
        @(negedge clk); upd_stb = 1'b1; m_word = m_pend; exp_q.push_back(model_step());
        @(negedge clk); upd_stb = 1'b0;
        check(code_valid == 1'b0, "R2 valid after strobe edge", int'(code_valid), 0);
        @(negedge clk);
        check(code_valid == 1'b1, "R2 valid on second edge", int'(code_valid), 1);
        @(negedge clk);
        check(code_valid == 1'b0, "R2 valid one cycle", int'(code_valid), 0);
        repeat (2) @(negedge clk);

        // R6 zero fraction from reset
        do_reset();
        load(1234 << 8);
        base = got.size();
        run(20);
        for (int k = base; k < got.size(); k++)
            check(got[k] == 1234, "R6 constant code", got[k], 1234);

        // R7 half fraction from reset
        do_reset();
        load((1000 << 8) | 128);
        base = got.size();
        run(16);
        for (int k = base; k < got.size(); k++)
            check(got[k] == 1000 || got[k] == 1001, "R7 code set", got[k], 1000);
        for (int k = base; k + 3 < got.size(); k++) begin
            s = got[k] + got[k+1] + got[k+2] + got[k+3];
            check(s == 4002, "R7 four-sum", s, 4002);
        end

        // R8 mean over 256
        load((16'h1234 << 8) | 8'h37);
        step();
        base = got.size();
        run(256);
        s = 0;
        for (int k = base; k < base + 256; k++) s += got[k];
        check(s >= 256*16'h1234 + 8'h37 - 1 && s <= 256*16'h1234 + 8'h37 + 1,
              "R8 256-sum", s, 256*16'h1234 + 8'h37);

        // R4 load without strobe has no effect
        v0 = int'(code);
        base = n_valid;
        load(24'h0100FF);
        repeat (6) @(negedge clk);
        check(int'(code) == v0, "R4 code unchanged by load", int'(code), v0);
        check(n_valid == base, "R4 no valid from load", n_valid, base);
        // R4 load in same cycle as strobe is used
        @(negedge clk); upd_stb = 1'b1; load_valid = 1'b1; load_word = 24'h030000;
        m_pend = 24'h030000; m_word = m_pend; exp_q.push_back(model_step());
        @(negedge clk); upd_stb = 1'b0; load_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R3 back-to-back strobes give one code
        base = n_valid;
        @(negedge clk); upd_stb = 1'b1; m_word = m_pend; exp_q.push_back(model_step());
        @(negedge clk);
        @(negedge clk); upd_stb = 1'b0;
        repeat (4) @(negedge clk);
        check(n_valid == base + 1, "R3 single code", n_valid, base + 1);

        // R9 top and bottom saturation
        load(24'hFFFFC0);
        base = got.size();
        run(8);
        for (int k = base; k < got.size(); k++)
            check(got[k] == 65535, "R9 top pinned", got[k], 65535);
        load(24'h000040);
        base = got.size();
        run(16);
        for (int k = base; k < got.size(); k++)
            check(got[k] >= 0 && got[k] <= 2, "R9 bottom range", got[k], 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all codes produced", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule